// File: doc/BRIEF.md
# Selectable Clock Output Generator

This block drives a single square-wave pin from the timekeeping time base. A three-bit select field picks one of seven output rates, or parks the pin low. The time base is either a crystal-derived prescaler tick or a mains line tick. A source bit chooses between them, and a second bit says whether the line runs at 50 Hz or 60 Hz.

The output comes straight from a register. It is forced low, and the divider is held cleared, while the power-down flag is set. Any change of the select field, the source bit or the line-rate bit restarts the divider cleanly. After a restart the output always begins with a full low phase.

With the line time base, the two slowest codes give 2 Hz and 1 Hz. The faster codes divide the line tick by powers of two. At 50 Hz the 2 Hz rate cannot be split evenly, so its high phase is one line cycle longer than its low phase.

Top module: `clkout_gen`

## Requirements
- R1: While `rst` is sampled high, `clk_out` is low and the divider is cleared, whatever ticks arrive.
- R2: Select code 0 holds `clk_out` low on every cycle, on either time-base source.
- R3: With `line_src`=0, select code k (1 to 7) gives low and high phases of 2^(k-1) crystal ticks each; code 7 is 1 Hz for a 128 Hz crystal tick. `line_50` has no effect in this mode.
- R4: Only the tick input named by `line_src` (0 = `xtal_tick`, 1 = `line_tick`) advances the divider. Pulses on the other tick input leave `clk_out` unchanged.
- R5: With `line_src`=1, select codes 1 to 5 give low and high phases of 2^(k-1) line ticks each, at either line rate.
- R6: With `line_src`=1, select code 7 is 1 Hz: phases of 30 line ticks when `line_50`=0 and 25 line ticks when `line_50`=1.
- R7: With `line_src`=1 and `line_50`=0, select code 6 is 2 Hz with 15-tick low and 15-tick high phases.
- R8: With `line_src`=1 and `line_50`=1, select code 6 is 2 Hz with a 12-tick low phase followed by a 13-tick high phase.
- R9: When `pdown` is sampled high, `clk_out` is low from the next cycle on, for as long as it stays set, and ticks are not counted. After release the output starts a fresh low phase.
- R10: A change of `sel`, `line_src` or `line_50` drives `clk_out` low on the next cycle. A tick sampled in that same cycle is discarded, and a full low phase of the new setting follows.
- R11: `clk_out` changes only at a clock edge that samples a selected tick, or on a restart, power-down or reset. A phase change becomes visible one cycle after the final tick of the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xtal_tick | input | 1 | One-cycle pulse from the crystal prescaler |
| line_tick | input | 1 | One-cycle pulse per mains line cycle |
| sel | input | 3 | Output rate select; 0 parks the output low |
| line_src | input | 1 | 1 selects the line tick as time base |
| line_50 | input | 1 | 1 for a 50 Hz line, 0 for 60 Hz |
| pdown | input | 1 | Power-down flag; forces the output low |
| clk_out | output | 1 | Square-wave clock output |

## Verification
The bench sweeps every nonzero select code under three time-base settings: crystal, 60 Hz line and 50 Hz line. For each setting it feeds more than two full output periods of ticks. Each sample is compared against a phase position computed from the tick count, so a wrong divide ratio, a swapped phase order or an off-by-one shows up at a specific tick.

Further sequences cover these cases:
- pulses on the unselected tick input;
- a tick landing in the same cycle as a select change;
- power-down asserted during a high phase;
- idle gaps between ticks;
- the unequal 12/13 split, which is measured directly.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 2 ** SEL_W;
    localparam int MAX_HALF  = 2 ** (NUM_CODES - 2);
    localparam int CNT_W     = $clog2(MAX_HALF + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             line_src;
        logic             line_50;
    } cfg_t;

    typedef struct packed {
        cnt_t lo;
        cnt_t hi;
    } half_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Number of ticks in the high part of an odd-split period (rounded up)
    function automatic int split_up(input int hz);
        return ((hz / 2) + 1) / 2;
    endfunction

    // Number of ticks in the low part of an odd-split period (rounded down)
    function automatic int split_dn(input int hz);
        return (hz / 2) / 2;
    endfunction

endpackage

// File: rtl/clkout_cfg_track.sv
module clkout_cfg_track
    import clkout_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    input  logic xtal_tick,
    input  logic line_tick,
    output logic restart,
    output logic tick_sel
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_in;
    end

    always_comb begin
        restart  = (cfg_in != cfg_q);
        tick_sel = cfg_in.line_src ? line_tick : xtal_tick;
    end

endmodule

// File: rtl/clkout_phase_rom.sv
module clkout_phase_rom
    import clkout_pkg::*;
#(
    parameter int LINE_HZ_FAST = 60,
    parameter int LINE_HZ_SLOW = 50
) (
    input  cfg_t  cfg,
    output half_t lens
);

    localparam logic [SEL_W-1:0] CODE_1HZ = SEL_W'(NUM_CODES - 1);
    localparam logic [SEL_W-1:0] CODE_2HZ = SEL_W'(NUM_CODES - 2);

    localparam cnt_t SEC_FAST = cnt_t'(LINE_HZ_FAST / 2);
    localparam cnt_t SEC_SLOW = cnt_t'(LINE_HZ_SLOW / 2);
    localparam cnt_t UP_FAST  = cnt_t'(split_up(LINE_HZ_FAST));
    localparam cnt_t DN_FAST  = cnt_t'(split_dn(LINE_HZ_FAST));
    localparam cnt_t UP_SLOW  = cnt_t'(split_up(LINE_HZ_SLOW));
    localparam cnt_t DN_SLOW  = cnt_t'(split_dn(LINE_HZ_SLOW));

    cnt_t pow_tab [NUM_CODES];

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_tab
        if (k == 0) begin : g_zero
            assign pow_tab[k] = cnt_t'(1);
        end else begin : g_pow
            assign pow_tab[k] = cnt_t'(1 << (k - 1));
        end
    end

    always_comb begin
        lens.lo = pow_tab[cfg.sel];
        lens.hi = pow_tab[cfg.sel];
        if (cfg.line_src && (cfg.sel == CODE_1HZ)) begin
            lens.lo = cfg.line_50 ? SEC_SLOW : SEC_FAST;
            lens.hi = cfg.line_50 ? SEC_SLOW : SEC_FAST;
        end else if (cfg.line_src && (cfg.sel == CODE_2HZ)) begin
            lens.lo = cfg.line_50 ? DN_SLOW : DN_FAST;
            lens.hi = cfg.line_50 ? UP_SLOW : UP_FAST;
        end
    end

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
    import clkout_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  tick,
    input  half_t lens,
    output logic  level
);

    phase_e phase_q;
    cnt_t   cnt_q;
    cnt_t   cur_len;
    cnt_t   cnt_nx;

    always_comb begin
        cur_len = (phase_q == PH_HIGH) ? lens.hi : lens.lo;
        cnt_nx  = cnt_q + cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else if (tick) begin
            if (cnt_nx == cur_len) begin
                cnt_q   <= '0;
                phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
            end else begin
                cnt_q <= cnt_nx;
            end
        end
    end

    assign level = (phase_q == PH_HIGH);

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int LINE_HZ_FAST = 60,
    parameter int LINE_HZ_SLOW = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_tick,
    input  logic             line_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             line_src,
    input  logic             line_50,
    input  logic             pdown,
    output logic             clk_out
);

    cfg_t  cfg;
    half_t lens;
    logic  restart;
    logic  tick_sel;
    logic  hold;

    always_comb begin
        cfg.sel      = sel;
        cfg.line_src = line_src;
        cfg.line_50  = line_50;
    end

    clkout_cfg_track u_track (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg),
        .xtal_tick (xtal_tick),
        .line_tick (line_tick),
        .restart   (restart),
        .tick_sel  (tick_sel)
    );

    clkout_phase_rom #(
        .LINE_HZ_FAST (LINE_HZ_FAST),
        .LINE_HZ_SLOW (LINE_HZ_SLOW)
    ) u_rom (
        .cfg  (cfg),
        .lens (lens)
    );

    // Divider is held cleared whenever the output must sit low or start afresh
    assign hold = restart | pdown | (sel == '0);

    clkout_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .tick  (tick_sel),
        .lens  (lens),
        .level (clk_out)
    );

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk
    import clkout_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             xtal_tick,
    input logic             line_tick,
    input logic [SEL_W-1:0] sel,
    input logic             line_src,
    input logic             line_50,
    input logic             pdown,
    input logic             clk_out
);

    logic             tick_now;
    logic [SEL_W+1:0] cfg_v;

    assign tick_now = line_src ? line_tick : xtal_tick;
    assign cfg_v    = {sel, line_src, line_50};

    AST_SEL0_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(sel == '0) |-> !clk_out); // R2

    AST_PDOWN_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(pdown) |-> !clk_out); // R9

    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_v) |=> !clk_out); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick_now && $stable(cfg_v) && !pdown) |=> $stable(clk_out)); // R11

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> $past(tick_now)); // R11

endmodule

bind clkout_gen clkout_gen_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .xtal_tick (xtal_tick),
    .line_tick (line_tick),
    .sel       (sel),
    .line_src  (line_src),
    .line_50   (line_50),
    .pdown     (pdown),
    .clk_out   (clk_out)
);

// File: tb/clkout_gen_tb_top.sv
`timescale 1ns/1ps
module clkout_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xtal_tick = 1'b0;
    logic       line_tick = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       line_src = 1'b0;
    logic       line_50 = 1'b0;
    logic       pdown = 1'b0;
    logic       clk_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clkout_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .xtal_tick (xtal_tick),
        .line_tick (line_tick),
        .sel       (sel),
        .line_src  (line_src),
        .line_50   (line_50),
        .pdown     (pdown),
        .clk_out   (clk_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected %0d", req, act, exp);
        end
    endtask

    // Change configuration at a falling edge; one rising edge applies the restart
    task automatic apply_cfg(input int s, input bit ls, input bit l50);
        sel      = s[2:0];
        line_src = ls;
        line_50  = l50;
        @(negedge clk);
    endtask

    // One tick on the chosen input, sampled at the next rising edge
    task automatic pulse(input bit on_line);
        if (on_line) line_tick = 1'b1;
        else         xtal_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        xtal_tick = 1'b0;
    endtask

    function automatic int half_exp(input int s, input bit ls, input bit l50, input bit hi);
        if (ls && s == 7) return l50 ? 25 : 30;
        if (ls && s == 6) return l50 ? (hi ? 13 : 12) : 15;
        return 1 << (s - 1);
    endfunction

    task automatic run_cfg(input int s, input bit ls, input bit l50, input string req);
        int lo;
        int hi;
        int per;
        lo  = half_exp(s, ls, l50, 1'b0);
        hi  = half_exp(s, ls, l50, 1'b1);
        per = lo + hi;
        apply_cfg(s, ls, l50);
        chk("R10", clk_out, 1'b0);
        for (int t = 1; t <= 2 * per + 2; t++) begin
            pulse(ls);
            chk(req, clk_out, ((t % per) >= lo) ? 1'b1 : 1'b0);
        end
    endtask

    initial begin
        // R1: reset holds output low even with ticks arriving
        @(negedge clk);
        sel       = 3'd1;
        xtal_tick = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R1", clk_out, 1'b0);
        end
        xtal_tick = 1'b0;
        sel       = 3'd0;
        rst       = 1'b0;
        @(negedge clk);
        chk("R1", clk_out, 1'b0);

        // R2: code 0 parks output low on both sources
        for (int i = 0; i < 12; i++) begin
            pulse(1'b0);
            chk("R2", clk_out, 1'b0);
        end
        apply_cfg(0, 1'b1, 1'b1);
        for (int i = 0; i < 12; i++) begin
            pulse(1'b1);
            chk("R2", clk_out, 1'b0);
        end

        // R3: crystal sweep; line_50 must not matter
        for (int s = 1; s <= 7; s++) run_cfg(s, 1'b0, 1'b0, "R3");
        run_cfg(7, 1'b0, 1'b1, "R3");
        run_cfg(6, 1'b0, 1'b1, "R3");

        // R5: line power-of-two codes at both line rates
        for (int s = 1; s <= 5; s++) begin
            run_cfg(s, 1'b1, 1'b0, "R5");
            run_cfg(s, 1'b1, 1'b1, "R5");
        end

        // R6, R7, R8: line 1 Hz and 2 Hz
        run_cfg(7, 1'b1, 1'b0, "R6");
        run_cfg(7, 1'b1, 1'b1, "R6");
        run_cfg(6, 1'b1, 1'b0, "R7");
        run_cfg(6, 1'b1, 1'b1, "R8");

        // R8: measure the unequal 2 Hz split directly
        apply_cfg(0, 1'b1, 1'b1);
        apply_cfg(6, 1'b1, 1'b1);
        begin
            int n_lo;
            int n_hi;
            n_lo = 0;
            n_hi = 0;
            while (clk_out !== 1'b1 && n_lo < 40) begin
                pulse(1'b1);
                n_lo++;
            end
            while (clk_out === 1'b1 && n_hi < 40) begin
                pulse(1'b1);
                n_hi++;
            end
            chk_int("R8 low", n_lo, 12);
            chk_int("R8 high", n_hi, 13);
        end

        // R4: unselected tick input is ignored
        apply_cfg(1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1);
            chk("R4", clk_out, 1'b0);
        end
        pulse(1'b0);
        chk("R4", clk_out, 1'b1);
        apply_cfg(1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            pulse(1'b0);
            chk("R4", clk_out, 1'b0);
        end
        pulse(1'b1);
        chk("R4", clk_out, 1'b1);

        // R9: power-down during a high phase
        apply_cfg(3, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) pulse(1'b0);
        chk("R9", clk_out, 1'b1);
        pdown = 1'b1;
        @(negedge clk);
        chk("R9", clk_out, 1'b0);
        for (int i = 0; i < 6; i++) begin
            pulse(1'b0);
            chk("R9", clk_out, 1'b0);
        end
        pdown = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            pulse(1'b0);
            chk("R9", clk_out, 1'b0);
        end
        pulse(1'b0);
        chk("R9", clk_out, 1'b1);

        // R10: select change mid-phase with a coincident tick
        apply_cfg(4, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) pulse(1'b0);
        chk("R10", clk_out, 1'b1);
        sel       = 3'd2;
        xtal_tick = 1'b1;
        @(negedge clk);
        xtal_tick = 1'b0;
        chk("R10", clk_out, 1'b0);
        pulse(1'b0);
        chk("R10", clk_out, 1'b0);
        pulse(1'b0);
        chk("R10", clk_out, 1'b1);

        // R11: idle cycles between ticks do not move the output
        apply_cfg(1, 1'b0, 1'b0);
        pulse(1'b0);
        chk("R11", clk_out, 1'b1);
        repeat (5) begin
            @(negedge clk);
            chk("R11", clk_out, 1'b1);
        end
        pulse(1'b0);
        chk("R11", clk_out, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run not finished, cycles=200000 expected fewer");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule